// File: doc/BRIEF.md
# Multi-Line Transmit DMA Scheduler

This block feeds bytes from memory to sixteen serial transmitters. Each line has a 16-bit current address, two extra high address bits and a 16-bit byte counter. The host reaches all three through one shared register window. A line number written into the control register picks which line the address and counter registers show. The host starts a line by loading its address and a negative byte count, then setting that line's bit in the active mask.

The scheduler serves the active lines in turn. It fetches one byte per turn over a single-outstanding memory read port and passes the byte to the line's transmitter. It only does this while that transmitter reports an empty holding register. Each byte advances the line's address and moves its counter one step toward zero. When the counter reaches zero, the line's active bit drops and the transmit interrupt flag is raised. A per-line break mask is also kept here and driven out to hold chosen lines in the spacing state.

Top module: `txdma_sched`

## Requirements
- R1: After reset, every host register reads zero, `mem_req`, `tx_load` and `irq` are low, and `line_break` is zero.
- R2: Register 0 is the control register. A write to it sets the selected line from bits 3:0 and writes bits 5:4 into that line's address bits 17:16. Registers 1 (address) and 2 (count) then read and write the selected line, and `mem_addr` is {bits 17:16, address}.
- R3: For a granted line, `mem_req` carries that line's 18-bit address. In the cycle after the edge where `mem_ack` is taken without `mem_err`, `tx_load` is one-hot for that line and `tx_data` holds `mem_rdata`. The line's address and count each go up by one.
- R4: When a byte brings a line's count to zero, that line's bit in register 3 clears and control bit 15 (transmit interrupt flag) sets. `irq` equals bit 15 AND bit 13 (enable).
- R5: Active lines are served in rotating order, one byte per grant, starting after the line granted last.
- R6: A line is never requested while its `tx_ready` bit is low, and `mem_req` stays low when no active line is ready.
- R7: Writing 16'hFFFF to the selected line's count makes that line send exactly one more byte before its active bit clears. That byte is the one in flight if a fetch is pending, otherwise the next one.
- R8: Control bit 15 stays set until the host writes 0 to it. Writing 1 leaves it unchanged.
- R9: A read answered with `mem_err` sets control bit 10 and clears the line's active bit (setting bit 15). It loads no byte and leaves that line's address and count unchanged. A control write with bit 8 set clears bit 10.
- R10: Register 4 holds one break bit per line, is readable, and drives `line_break` directly.
- R11: Writing register 3 only sets bits. Zeros in the written value leave active lines running.
- R12: Once raised, `mem_req` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host register index (0 ctrl, 1 address, 2 count, 3 active, 4 break) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_sel`, combinational |
| irq | output | 1 | Transmit interrupt request |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 18 | Byte address of the request |
| mem_ack | input | 1 | Memory read completion |
| mem_err | input | 1 | Completion reports non-existent memory |
| mem_rdata | input | 8 | Byte returned with `mem_ack` |
| tx_ready | input | 16 | Per-line transmitter holding register empty |
| tx_load | output | 16 | Per-line one-cycle load strobe |
| tx_data | output | 8 | Byte for the strobed line |
| line_break | output | 16 | Per-line force-spacing outputs |

## Verification
Host writes take effect at the next clock edge, and register reads are combinational. The bench therefore reads back one clock after each write, between edges.

A request rises one edge after a line becomes eligible. The load strobe, the address and count steps and the active-bit clear all appear at the edge that takes `mem_ack`. The bench logs each one-cycle `tx_load` at the falling edge, so every byte is seen exactly once. It compares that log with an order and data computed from its own rotation model and address function.

Completion is checked by polling the active mask, never by fixed delays. The stop case counts the loads seen before the falling edge on which the stop write is driven. The error case and the ignored-write cases are read back through the registers and ports once the line has settled.

// File: rtl/txdma_sched.sv
module txdma_sched #(
  parameter int NLINES = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic [17:0]       mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [NLINES-1:0] tx_ready,
  output logic [NLINES-1:0] tx_load,
  output logic [DW-1:0]     tx_data,
  output logic [NLINES-1:0] line_break
);
  localparam int SW = $clog2(NLINES);
  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_ADDR = 3'd1;
  localparam logic [2:0] RG_CNT  = 3'd2;
  localparam logic [2:0] RG_ACT  = 3'd3;
  localparam logic [2:0] RG_BRK  = 3'd4;

  logic [15:0]       lo_q  [NLINES];
  logic [1:0]        hi_q  [NLINES];
  logic [15:0]       cnt_q [NLINES];
  logic [15:0]       lo_nx [NLINES];
  logic [15:0]       cnt_nx[NLINES];
  logic [NLINES-1:0] act_q, brk_q, elig, done_v;
  logic [SW-1:0]     sel_q, cur_q, last_q, pick;
  logic              tie_q, ti_q, nxm_q, busy_q, found;
  logic [17:0]       addr_q;

  wire wr_ctrl = host_we && host_sel == RG_CTRL;
  wire wr_addr = host_we && host_sel == RG_ADDR;
  wire wr_cnt  = host_we && host_sel == RG_CNT;
  wire wr_act  = host_we && host_sel == RG_ACT;
  wire wr_brk  = host_we && host_sel == RG_BRK;
  wire fire    = busy_q & mem_ack;
  wire good    = fire & ~mem_err;
  wire bad     = fire & mem_err;

  assign irq        = ti_q & tie_q;
  assign mem_req    = busy_q;
  assign mem_addr   = addr_q;
  assign line_break = brk_q;
  assign elig       = act_q & tx_ready & ~tx_load;

  always_comb begin
    found = 1'b0;
    pick  = last_q;
    for (int i = 1; i <= NLINES; i++) begin
      int k;
      k = (int'(last_q) + i) % NLINES;
      if (!found && elig[k]) begin
        found = 1'b1;
        pick  = SW'(k);
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NLINES; n++) begin
      lo_nx[n]  = (wr_addr && sel_q == SW'(n)) ? host_wdata : lo_q[n];
      cnt_nx[n] = (wr_cnt  && sel_q == SW'(n)) ? host_wdata : cnt_q[n];
      if (good && cur_q == SW'(n)) begin
        lo_nx[n]  = lo_nx[n] + 16'd1;
        cnt_nx[n] = cnt_nx[n] + 16'd1;
      end
      done_v[n] = fire && cur_q == SW'(n) && (mem_err || cnt_nx[n] == 16'd0);
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      RG_CTRL: begin
        host_rdata[15]     = ti_q;
        host_rdata[13]     = tie_q;
        host_rdata[10]     = nxm_q;
        host_rdata[5:4]    = hi_q[sel_q];
        host_rdata[SW-1:0] = sel_q;
      end
      RG_ADDR: host_rdata = lo_q[sel_q];
      RG_CNT:  host_rdata = cnt_q[sel_q];
      RG_ACT:  host_rdata[NLINES-1:0] = act_q;
      RG_BRK:  host_rdata[NLINES-1:0] = brk_q;
      default: host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NLINES; n++) begin
        lo_q[n]  <= '0;
        hi_q[n]  <= '0;
        cnt_q[n] <= '0;
      end
      act_q   <= '0;
      brk_q   <= '0;
      sel_q   <= '0;
      cur_q   <= '0;
      last_q  <= '0;
      tie_q   <= 1'b0;
      ti_q    <= 1'b0;
      nxm_q   <= 1'b0;
      busy_q  <= 1'b0;
      addr_q  <= '0;
      tx_load <= '0;
      tx_data <= '0;
    end else begin
      for (int n = 0; n < NLINES; n++) begin
        lo_q[n]  <= lo_nx[n];
        cnt_q[n] <= cnt_nx[n];
      end
      if (wr_ctrl) begin
        sel_q <= host_wdata[SW-1:0];
        hi_q[host_wdata[SW-1:0]] <= host_wdata[5:4];
        tie_q <= host_wdata[13];
      end
      ti_q  <= (|done_v) | (ti_q & ~(wr_ctrl & ~host_wdata[15]));
      nxm_q <= bad | (nxm_q & ~(wr_ctrl & host_wdata[8]));
      act_q <= (act_q | (wr_act ? host_wdata[NLINES-1:0] : '0)) & ~done_v;
      if (wr_brk) brk_q <= host_wdata[NLINES-1:0];
      tx_load <= '0;
      if (good) begin
        tx_load[cur_q] <= 1'b1;
        tx_data        <= mem_rdata;
      end
      if (fire) begin
        busy_q <= 1'b0;
      end else if (!busy_q && found) begin
        busy_q <= 1'b1;
        cur_q  <= pick;
        last_q <= pick;
        addr_q <= {hi_q[pick], lo_q[pick]};
      end
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R3
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_load));

  // R4
  ti_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(act_q) & ~act_q)) |-> ti_q);

  // R4
  act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(act_q) & ~act_q)) |-> $past(mem_req && mem_ack));

  // R9
  nxm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> nxm_q && tx_load == '0);

  // R6
  req_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(act_q) != '0);
endmodule

// File: tb/txdma_sched_tb_top.sv
module txdma_sched_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_sel = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq, mem_req;
  logic [17:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [N-1:0] tx_ready = '0;
  logic [N-1:0] ready_en = '1;
  logic [N-1:0] tx_load, line_break;
  logic [7:0]  tx_data;

  int n_chk = 0, n_fail = 0;
  int mem_lat = 0, wcnt = 0;
  int log_line [0:511];
  int log_data [0:511];
  int log_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  txdma_sched dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .tx_ready(tx_ready),
    .tx_load(tx_load), .tx_data(tx_data), .line_break(line_break)
  );

  function automatic logic [7:0] mval(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]};
  endfunction

  function automatic logic [15:0] mk(input bit ti, input bit tie, input bit clr,
                                     input logic [1:0] hi, input logic [3:0] sel);
    return {ti, 1'b0, tie, 4'b0, clr, 2'b0, hi, sel};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt >= mem_lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mval(mem_addr);
        mem_err   <= (mem_addr[17:16] == 2'b11);
        wcnt      <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) tx_ready <= rst_n ? (ready_en & ~tx_load) : '0;

  always @(negedge clk) begin
    if (|tx_load) begin
      for (int i = 0; i < N; i++)
        if (tx_load[i]) log_line[log_n] = i;
      log_data[log_n] = int'(tx_data);
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] d);
    @(negedge clk);
    host_sel = s;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle(input logic [15:0] mask);
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, v);
      if ((v & mask) == 0) break;
    end
  endtask

  task automatic setup_line(input int l, input logic [1:0] hi, input logic [15:0] a,
                            input logic [15:0] c);
    wr(3'd0, mk(1, 1, 0, hi, 4'(l)));
    wr(3'd1, a);
    wr(3'd2, c);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int r = 0; r < 5; r++) begin
      rd(3'(r), v);
      check(v == 0, "R1 register", int'(v), 0);
    end
    check(!mem_req && tx_load == 0 && !irq && line_break == 0, "R1 outputs",
          int'({mem_req, irq, tx_load}), 0);
  endtask

  task automatic t_single;
    logic [15:0] v;
    int base;
    ready_en = '1;
    wr(3'd0, mk(0, 1, 0, 2'b01, 4'd3));
    wr(3'd1, 16'h1000);
    wr(3'd2, 16'hFFFD);
    base = log_n;
    wr(3'd3, 16'h0008);
    wait_idle(16'h0008);
    check(log_n - base == 3, "R3 byte count", log_n - base, 3);
    for (int i = 0; i < 3; i++) begin
      check(log_line[base+i] == 3, "R3 line", log_line[base+i], 3);
      check(log_data[base+i] == int'(mval({2'b01, 16'h1000 + 16'(i)})), "R2 data/high bits",
            log_data[base+i], int'(mval({2'b01, 16'h1000 + 16'(i)})));
    end
    rd(3'd1, v); check(v == 16'h1003, "R3 address advance", int'(v), 'h1003);
    rd(3'd2, v); check(v == 16'h0000, "R4 count zero", int'(v), 0);
    rd(3'd0, v); check(v[15] == 1'b1 && v[5:4] == 2'b01 && v[3:0] == 4'd3, "R4 flag", int'(v), 'ha013);
    check(irq == 1'b1, "R4 irq", int'(irq), 1);
  endtask

  task automatic t_sticky;
    logic [15:0] v;
    wr(3'd0, mk(1, 1, 0, 2'b01, 4'd3));
    rd(3'd0, v); check(v[15] == 1'b1, "R8 write one keeps flag", int'(v[15]), 1);
    wr(3'd0, mk(0, 1, 0, 2'b01, 4'd3));
    rd(3'd0, v); check(v[15] == 1'b0, "R8 write zero clears flag", int'(v[15]), 0);
    check(irq == 1'b0, "R8 irq cleared", int'(irq), 0);
  endtask

  task automatic t_rr;
    int rem [N];
    int last, base, exp_l, k;
    logic [15:0] a;
    for (int i = 0; i < N; i++) rem[i] = 0;
    rem[1] = 2; rem[5] = 2; rem[9] = 2;
    for (int l = 1; l < 10; l += 4) setup_line(l, 2'b00, 16'(l * 256), 16'hFFFE);
    last = log_line[log_n-1];
    base = log_n;
    wr(3'd3, 16'h0222);
    wait_idle(16'h0222);
    check(log_n - base == 6, "R5 total bytes", log_n - base, 6);
    for (int j = 0; j < 6; j++) begin
      exp_l = -1;
      for (int i = 1; i <= N; i++) begin
        k = (last + i) % N;
        if (exp_l < 0 && rem[k] > 0) exp_l = k;
      end
      a = 16'(exp_l * 256 + (2 - rem[exp_l]));
      rem[exp_l]--;
      last = exp_l;
      check(log_line[base+j] == exp_l, "R5 rotation order", log_line[base+j], exp_l);
      check(log_data[base+j] == int'(mval({2'b00, a})), "R5 data", log_data[base+j], int'(mval({2'b00, a})));
    end
  endtask

  task automatic t_gate;
    logic [15:0] v;
    int base, reqs;
    ready_en = ~16'h0004;
    setup_line(2, 2'b00, 16'h2000, 16'hFFFF);
    base = log_n;
    wr(3'd3, 16'h0004);
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    check(reqs == 0, "R6 no request while not ready", reqs, 0);
    check(log_n == base, "R6 no load while not ready", log_n - base, 0);
    rd(3'd3, v); check(v[2] == 1'b1, "R6 line still active", int'(v), 4);
    rd(3'd2, v); check(v == 16'hFFFF, "R6 count untouched", int'(v), 'hFFFF);
    ready_en = '1;
    wait_idle(16'h0004);
    check(log_n - base == 1 && log_line[base] == 2, "R6 runs once ready", log_n - base, 1);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    int base, n6;
    mem_lat = 3;
    setup_line(6, 2'b00, 16'h3000, 16'hFF9C);
    base = log_n;
    wr(3'd3, 16'h0040);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (log_n - base >= 2) break;
    end
    n6 = log_n - base;
    host_we = 1'b1; host_sel = 3'd2; host_wdata = 16'hFFFF;
    @(negedge clk);
    host_we = 1'b0;
    wait_idle(16'h0040);
    check(log_n - base == n6 + 1, "R7 one byte after stop", log_n - base, n6 + 1);
    rd(3'd1, v);
    check(v == 16'(16'h3000 + n6 + 1), "R7 address shows consumed", int'(v), 'h3000 + n6 + 1);
    mem_lat = 0;
  endtask

  task automatic t_nxm;
    logic [15:0] v;
    int base;
    wr(3'd0, mk(0, 1, 0, 2'b11, 4'd7));
    wr(3'd1, 16'h0200);
    wr(3'd2, 16'hFFFE);
    base = log_n;
    wr(3'd3, 16'h0080);
    wait_idle(16'h0080);
    rd(3'd0, v);
    check(v[10] == 1'b1 && v[15] == 1'b1, "R9 error and flag", int'(v), 'ha437);
    check(log_n == base, "R9 no byte loaded", log_n - base, 0);
    rd(3'd1, v); check(v == 16'h0200, "R9 address kept", int'(v), 'h200);
    rd(3'd2, v); check(v == 16'hFFFE, "R9 count kept", int'(v), 'hFFFE);
    wr(3'd0, mk(1, 1, 1, 2'b11, 4'd7));
    rd(3'd0, v); check(v[10] == 1'b0, "R9 error cleared", int'(v[10]), 0);
  endtask

  task automatic t_actwr;
    logic [15:0] v;
    int base;
    ready_en = ~16'h0100;
    setup_line(8, 2'b00, 16'h4000, 16'hFFFF);
    base = log_n;
    wr(3'd3, 16'h0100);
    wr(3'd3, 16'h0000);
    rd(3'd3, v); check(v[8] == 1'b1, "R11 zero write ignored", int'(v), 'h100);
    ready_en = '1;
    wait_idle(16'h0100);
    check(log_n - base == 1 && log_line[base] == 8, "R11 line completes", log_n - base, 1);
  endtask

  task automatic t_break;
    logic [15:0] v;
    wr(3'd4, 16'hA5C3);
    check(line_break == 16'hA5C3, "R10 break outputs", int'(line_break), 'hA5C3);
    rd(3'd4, v); check(v == 16'hA5C3, "R10 break readback", int'(v), 'hA5C3);
    wr(3'd4, 16'h0000);
    check(line_break == 16'h0000, "R10 break cleared", int'(line_break), 0);
  endtask

  task automatic t_irqmask;
    logic [15:0] v;
    wr(3'd0, mk(1, 0, 0, 2'b00, 4'd8));
    rd(3'd0, v);
    check(v[15] == 1'b1 && irq == 1'b0, "R4 irq masked by enable", int'(irq), 0);
    wr(3'd0, mk(1, 1, 0, 2'b00, 4'd8));
    check(irq == 1'b1, "R4 irq with enable", int'(irq), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_single;
    t_sticky;
    t_rr;
    t_gate;
    t_stop;
    t_nxm;
    t_actwr;
    t_break;
    t_irqmask;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule